// File: doc/BRIEF.md
# Bridge Master-Abort Responder

This block decides how a bridge finishes a transaction toward its initiator when the copy of that transaction on the far bus ends in master-abort. On each far-side completion strobe it looks at four things: the transaction class, the initiator's bus width, whether the 64-bit request was acknowledged, and a master-abort mode bit. One clock later it presents a response code and, where needed, all-ones read data.

It also drives the primary system-error output as one-clock active-low pulses. The sources are a posted write that was lost to master-abort and a forwarded secondary system-error assertion. The block gates secondary address and data parity error reporting behind an enable bit. A small three-bit control register, cleared by reset, holds the mode bit, the secondary system-error forward bit and the parity response bit. A separate global system-error enable comes in as an input. PCI signalling itself is outside this block.

Top module: `bridge_abort_resp`

## Requirements
- R1: The control register resets to 0. A cycle with `cfg_we` high loads `cfg_wdata` into it: bit 0 is master-abort mode, bit 1 is secondary SERR forward enable, bit 2 is secondary parity response enable.
- R2: `resp_vld` is high exactly one clock after `done_vld`. If `far_mabort` was low, `resp_code` is 00 (normal completion). Outside a code-01 response, `rd_data` is 0.
- R3: With mode clear, a master-aborted read (`txn_class` 00, or 11, which is treated as a read) gives `resp_code` 01 with all-ones data.
- R4: The all-ones data fills all DATA_W bits when both `init_wide` and `ack64` are high. Otherwise only the low DATA_W/2 bits are ones and the upper half is zero.
- R5: With mode clear, a master-aborted write of either class (01 non-posted, 10 posted) gives `resp_code` 11 (accepted and discarded). No system error is raised.
- R6: With mode set, a master-aborted read or non-posted write gives `resp_code` 10 (master-abort) with zero data.
- R7: With mode set, a master-aborted posted write gives `resp_code` 11. It pulses `p_serr_n` low in the response cycle only if `serr_en` was high.
- R8: A falling edge on `sec_serr_n` pulses `p_serr_n` low for one clock, on the next clock, only when both the forward bit and `serr_en` are set. Holding `sec_serr_n` low gives no further pulses.
- R9: A posted-write abort event and a secondary SERR event in the same cycle give a single one-clock pulse.
- R10: `perr_report` pulses one clock after `sec_addr_perr` or `sec_data_perr` only if the parity response bit is set. Otherwise those inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control register write data |
| serr_en | input | 1 | Global system-error enable |
| done_vld | input | 1 | Far-side completion strobe |
| txn_class | input | 2 | 00 read, 01 non-posted write, 10 posted write, 11 read |
| init_wide | input | 1 | Initiator is on a 64-bit bus |
| ack64 | input | 1 | 64-bit request acknowledged |
| far_mabort | input | 1 | Far-side transaction ended in master-abort |
| sec_serr_n | input | 1 | Secondary system-error input, active low |
| sec_addr_perr | input | 1 | Secondary address parity error detected |
| sec_data_perr | input | 1 | Secondary data parity error detected |
| resp_vld | output | 1 | Response valid |
| resp_code | output | 2 | Response code to initiator |
| rd_data | output | DATA_W | Read return data |
| p_serr_n | output | 1 | Primary system-error output, active low |
| perr_report | output | 1 | Secondary parity error report |

## Verification
The bench builds the block with DATA_W at its default of 64. At that width the full-width and half-width all-ones returns are told apart by their upper 32 bits alone. With every response and expected value at that width, the scoreboard can show both the half-width case and the case where the 64-bit request was not acknowledged. Timed stimulus on `sec_serr_n` alongside posted-write aborts brings the single-cycle merge and the edge-only forwarding within reach.

// File: rtl/bridge_abort_resp.sv
module bridge_abort_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wdata,
  input  logic              serr_en,
  input  logic              done_vld,
  input  logic [1:0]        txn_class,
  input  logic              init_wide,
  input  logic              ack64,
  input  logic              far_mabort,
  input  logic              sec_serr_n,
  input  logic              sec_addr_perr,
  input  logic              sec_data_perr,
  output logic              resp_vld,
  output logic [1:0]        resp_code,
  output logic [DATA_W-1:0] rd_data,
  output logic              p_serr_n,
  output logic              perr_report
);
  localparam int NARROW_W = DATA_W / 2;
  localparam logic [1:0] CLS_NPW    = 2'b01;
  localparam logic [1:0] CLS_POSTED = 2'b10;
  localparam logic [1:0] RC_NORMAL  = 2'b00;
  localparam logic [1:0] RC_ONES    = 2'b01;
  localparam logic [1:0] RC_MABORT  = 2'b10;
  localparam logic [1:0] RC_DISCARD = 2'b11;

  logic [2:0] ctl_q;
  wire ma_mode  = ctl_q[0];
  wire fwd_en   = ctl_q[1];
  wire perr_en  = ctl_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (cfg_we) ctl_q <= cfg_wdata;

  logic [1:0]        code_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    code_d = RC_NORMAL;
    data_d = '0;
    if (far_mabort) begin
      if (txn_class == CLS_POSTED)  code_d = RC_DISCARD;
      else if (ma_mode)             code_d = RC_MABORT;
      else if (txn_class == CLS_NPW) code_d = RC_DISCARD;
      else begin
        code_d = RC_ONES;
        data_d = (init_wide && ack64) ? {DATA_W{1'b1}}
                                      : {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resp_vld  <= 1'b0;
      resp_code <= RC_NORMAL;
      rd_data   <= '0;
    end else begin
      resp_vld  <= done_vld;
      resp_code <= done_vld ? code_d : RC_NORMAL;
      rd_data   <= done_vld ? data_d : '0;
    end

  logic sec_prev_q, serr_q;
  wire sec_fall = sec_prev_q & ~sec_serr_n;
  wire ma_evt   = done_vld & far_mabort & ma_mode & (txn_class == CLS_POSTED) & serr_en;
  wire sec_evt  = sec_fall & fwd_en & serr_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_prev_q  <= 1'b1;
      serr_q      <= 1'b0;
      perr_report <= 1'b0;
    end else begin
      sec_prev_q  <= sec_serr_n;
      serr_q      <= ma_evt | sec_evt;
      perr_report <= perr_en & (sec_addr_perr | sec_data_perr);
    end

  assign p_serr_n = ~serr_q;

  // R6
  ma_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && resp_code == RC_MABORT) |->
      ($past(ctl_q[0]) && $past(far_mabort) && $past(txn_class) != CLS_POSTED));

  // R4
  ones_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && resp_code == RC_ONES) |->
      ((&rd_data[NARROW_W-1:0]) &&
       ((&rd_data[DATA_W-1:NARROW_W]) || !(|rd_data[DATA_W-1:NARROW_W]))));

  // R2
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_data) |-> (resp_vld && resp_code == RC_ONES));

  // R8
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_serr_n |-> $past(serr_en));

  // R10
  perr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_report |-> $past(ctl_q[2]));
endmodule

// File: tb/sim_bridge_abort_resp.sv
module sim_bridge_abort_resp;
  localparam int DW = 64;
  localparam int NW = DW / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic serr_en = 1'b0, done_vld = 1'b0;
  logic [1:0] txn_class = '0;
  logic init_wide = 1'b0, ack64 = 1'b0, far_mabort = 1'b0;
  logic sec_serr_n = 1'b1, sec_addr_perr = 1'b0, sec_data_perr = 1'b0;
  logic resp_vld, p_serr_n, perr_report;
  logic [1:0] resp_code;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [DW+1:0] exp_q[$];
  string tag_q[$];

  localparam logic [DW-1:0] ONES_FULL = {DW{1'b1}};
  localparam logic [DW-1:0] ONES_HALF = {{NW{1'b0}}, {NW{1'b1}}};

  always #2 clk = ~clk;

  bridge_abort_resp #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .serr_en(serr_en), .done_vld(done_vld), .txn_class(txn_class),
    .init_wide(init_wide), .ack64(ack64), .far_mabort(far_mabort),
    .sec_serr_n(sec_serr_n), .sec_addr_perr(sec_addr_perr),
    .sec_data_perr(sec_data_perr), .resp_vld(resp_vld), .resp_code(resp_code),
    .rd_data(rd_data), .p_serr_n(p_serr_n), .perr_report(perr_report));

  task automatic check(string req, logic [DW+1:0] act, logic [DW+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_vld) begin
      if (exp_q.size() == 0) check("R2 unexpected response", {resp_code, rd_data}, '0);
      else check(tag_q.pop_front(), {resp_code, rd_data}, exp_q.pop_front());
    end
  end

  task automatic write_cfg(logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(string tag, logic [1:0] cls, logic wide, logic a64, logic mab,
                      logic gen, logic [1:0] code, logic [DW-1:0] data, logic serr_exp);
    @(negedge clk);
    txn_class = cls; init_wide = wide; ack64 = a64; far_mabort = mab;
    serr_en = gen; done_vld = 1'b1;
    exp_q.push_back({code, data}); tag_q.push_back(tag);
    @(negedge clk);
    done_vld = 1'b0; far_mabort = 1'b0;
    check({tag, " serr"}, {{DW+1{1'b0}}, p_serr_n}, {{DW+1{1'b0}}, ~serr_exp});
  endtask

  task automatic sec_fall(string tag, logic gen, logic exp_pulse);
    @(negedge clk); sec_serr_n = 1'b0; serr_en = gen;
    @(negedge clk);
    check({tag, " pulse"}, {{DW+1{1'b0}}, p_serr_n}, {{DW+1{1'b0}}, ~exp_pulse});
    @(negedge clk);
    check({tag, " held"}, {{DW+1{1'b0}}, p_serr_n}, {{DW+1{1'b0}}, 1'b1});
    sec_serr_n = 1'b1;
  endtask

  task automatic parity(string tag, logic a, logic d, logic exp_rep);
    @(negedge clk); sec_addr_perr = a; sec_data_perr = d;
    @(negedge clk);
    check(tag, {{DW+1{1'b0}}, perr_report}, {{DW+1{1'b0}}, exp_rep});
    sec_addr_perr = 1'b0; sec_data_perr = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 reset outputs", {resp_vld, resp_code, rd_data, p_serr_n, perr_report} ,
          {1'b0, 2'b00, {DW{1'b0}}, 1'b1, 1'b0});

    send("R2 normal read", 2'b00, 1, 1, 0, 1, 2'b00, '0, 0);
    send("R3 R4 full ones", 2'b00, 1, 1, 1, 1, 2'b01, ONES_FULL, 0);
    send("R4 no ack64", 2'b00, 1, 0, 1, 1, 2'b01, ONES_HALF, 0);
    send("R4 narrow init", 2'b00, 0, 1, 1, 1, 2'b01, ONES_HALF, 0);
    send("R3 class 11 read", 2'b11, 0, 0, 1, 1, 2'b01, ONES_HALF, 0);
    send("R5 npw discard", 2'b01, 1, 1, 1, 1, 2'b11, '0, 0);
    send("R5 R1 posted no serr", 2'b10, 1, 1, 1, 1, 2'b11, '0, 0);
    sec_fall("R1 R8 fwd off", 1, 0);
    parity("R1 R10 parity ignored", 1, 1, 0);

    write_cfg(3'b111);
    send("R6 read mabort", 2'b00, 1, 1, 1, 1, 2'b10, '0, 0);
    send("R6 npw mabort", 2'b01, 0, 0, 1, 1, 2'b10, '0, 0);
    send("R6 class 11 mabort", 2'b11, 1, 1, 1, 1, 2'b10, '0, 0);
    send("R7 posted serr", 2'b10, 1, 1, 1, 1, 2'b11, '0, 1);
    send("R7 posted gen off", 2'b10, 1, 1, 1, 0, 2'b11, '0, 0);
    send("R2 normal mode set", 2'b10, 1, 1, 0, 1, 2'b00, '0, 0);
    sec_fall("R8 forwarded", 1, 1);
    sec_fall("R8 gen off", 0, 0);

    // R9 merge: posted abort and secondary fall in the same cycle
    @(negedge clk);
    txn_class = 2'b10; far_mabort = 1'b1; serr_en = 1'b1; done_vld = 1'b1;
    sec_serr_n = 1'b0;
    exp_q.push_back({2'b11, {DW{1'b0}}}); tag_q.push_back("R9 merge resp");
    @(negedge clk);
    done_vld = 1'b0; far_mabort = 1'b0;
    check("R9 merge pulse", {{DW+1{1'b0}}, p_serr_n}, '0);
    @(negedge clk);
    check("R9 single pulse", {{DW+1{1'b0}}, p_serr_n}, {{DW+1{1'b0}}, 1'b1});
    sec_serr_n = 1'b1;

    parity("R10 addr perr", 1, 0, 1);
    parity("R10 data perr", 0, 1, 1);
    write_cfg(3'b011);
    parity("R10 disabled again", 1, 0, 0);

    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule